// File: doc/BRIEF.md
# Four-Bus DAC Level Writer

This block is an I2C write controller that sets the output level of four identical 8-bit DACs. All four DACs answer to the same device address. Each one therefore hangs on its own physical bus pair, and the block picks a DAC by steering its single bit engine onto one of four clock/data pin pairs. Pairs that are not selected are never driven.

A request carries a 2-bit channel index and an 8-bit level. On a request the block latches both. It then produces a START, the address byte (7-bit device address followed by a write bit of 0), an acknowledge slot, the level byte, a second acknowledge slot and a STOP. There is no register pointer. The DAC takes the single data byte as its new output level.

The block raises `busy` while a transfer runs and pulses `done` at the end. It sets a sticky `err` flag if either byte is not acknowledged. The pins use an open-drain scheme: a 1 on a `*_drv_low` output means "pull the line low", and `sda_line` returns the resolved level of each data line. The bus clock is derived from the system clock by a parameterized divider and runs at 100 kHz by default.

Top module: `dac_bus_writer`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and every bit of `scl_drv_low` and `sda_drv_low` is 0, so all lines are released.
- R2: An accepted request produces, on the selected pair, a START, the address byte {ADDR7, 1'b0} sent MSB first, an acknowledge slot, the level byte sent MSB first, an acknowledge slot and a STOP.
- R3: The channel index `req_chan` (0 to 3) selects bit `req_chan` of `scl_drv_low` and `sda_drv_low`. The other pairs show no START and no activity during that transfer.
- R4: `busy` is 1 from the cycle after the request is accepted until the transfer ends. A `req` arriving while `busy` is 1 is ignored: it starts no transfer and does not alter the channel or level of the running one.
- R5: `done` is high for exactly one cycle per transfer, after the STOP, and `busy` is 0 in that cycle.
- R6: If the address byte is not acknowledged (SDA high in its acknowledge slot), the level byte is not sent, a STOP follows and `err` becomes 1.
- R7: If the level byte is not acknowledged, a STOP follows and `err` becomes 1.
- R8: `err` stays 1 across later successful transfers until `err_clr` is pulsed, which returns it to 0. A new failure in the same cycle takes precedence over the clear.
- R9: Each SCL bit period is 4*QTR system clocks, where QTR = CLK_HZ / (4*SCL_HZ).
- R10: SDA changes while SCL is high only at START (falling) and STOP (rising): exactly two such changes per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, taken when idle |
| req_chan | input | 2 | Index of the target bus pair |
| req_level | input | 8 | Level byte for the DAC |
| err_clr | input | 1 | Clears the sticky error flag |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Sticky missing-acknowledge flag |
| scl_drv_low | output | 4 | Per-pair clock pull-down enable |
| sda_drv_low | output | 4 | Per-pair data pull-down enable |
| sda_line | input | 4 | Resolved level of each data line |

## Verification
The hardest case to reach from the ports is a missing acknowledge in one chosen slot, either on the address byte or on the level byte. This matters most when a request collides with a running transfer. The bench contains a per-pair responder that decodes START, bits and STOP from the pins. It can be told to withhold its acknowledge for a chosen byte index, which drives the abort paths on demand. It also issues a second request in the middle of a transfer, aimed at another pair, and then confirms that this pair never saw a START. Sweeps over all four channels with several level patterns check the byte contents, the SCL period and the count of SDA changes while SCL is high.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_BIT   = 3'd2,
    S_ACK   = 3'd3,
    S_STOP  = 3'd4
  } wr_state_e;

  // system clocks per quarter of an SCL period (at least one)
  function automatic int qtr_cycles(input int clk_hz, input int scl_hz);
    int q;
    q = clk_hz / (4 * scl_hz);
    return (q < 1) ? 1 : q;
  endfunction

  // first byte on the wire: 7-bit device address, write direction
  function automatic logic [7:0] addr_byte(input logic [6:0] dev);
    return {dev, 1'b0};
  endfunction

endpackage

// File: rtl/dac_wr_clkdiv.sv
module dac_wr_clkdiv #(
  parameter int QTR = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic qtick
);
  localparam int CW = $clog2(QTR + 1);

  logic [CW-1:0] cnt;

  assign qtick = run && (cnt == CW'(QTR - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (qtick)     cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  p_div_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(QTR));

  p_tick_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    qtick |=> !qtick);

endmodule

// File: rtl/dac_wr_engine.sv
module dac_wr_engine
  import dac_wr_pkg::*;
#(
  parameter int         CH_W  = 2,
  parameter logic [6:0] ADDR7 = 7'h4C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [CH_W-1:0] req_chan,
  input  logic [7:0]      req_level,
  input  logic            err_clr,
  input  logic            qtick,
  input  logic            sda_s,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [CH_W-1:0] chan_q,
  output logic            scl_low,
  output logic            sda_low
);

  wr_state_e  st;
  logic [1:0] qph;
  logic [2:0] bitn;
  logic [7:0] shreg;
  logic [7:0] level_q;
  logic       second;
  logic       bad;

  // named events for the assertions
  logic nack_ev;
  logic accept_ev;
  logic qend;

  assign busy      = (st != S_IDLE);
  assign accept_ev = (st == S_IDLE) && req;
  assign qend      = qtick && (qph == 2'd3);
  assign nack_ev   = (st == S_ACK) && qtick && (qph == 2'd1) && sda_s;

  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    unique case (st)
      S_IDLE: begin
        scl_low = 1'b0;
        sda_low = 1'b0;
      end
      S_START: begin
        sda_low = (qph >= 2'd2);
        scl_low = (qph == 2'd3);
      end
      S_BIT: begin
        scl_low = (qph == 2'd0) || (qph == 2'd3);
        sda_low = ~shreg[7];
      end
      S_ACK: begin
        scl_low = (qph == 2'd0) || (qph == 2'd3);
        sda_low = 1'b0;
      end
      S_STOP: begin
        scl_low = (qph == 2'd0);
        sda_low = (qph <= 2'd1);
      end
      default: begin
        scl_low = 1'b0;
        sda_low = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      qph     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      level_q <= '0;
      chan_q  <= '0;
      second  <= 1'b0;
      bad     <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (nack_ev)      err <= 1'b1;
      else if (err_clr) err <= 1'b0;

      if (accept_ev) begin
        st      <= S_START;
        chan_q  <= req_chan;
        level_q <= req_level;
        shreg   <= addr_byte(ADDR7);
        qph     <= '0;
        bitn    <= '0;
        second  <= 1'b0;
        bad     <= 1'b0;
      end else if (busy && qtick) begin
        qph <= qph + 2'd1;
        if (nack_ev) bad <= 1'b1;
        if (qph == 2'd3) begin
          unique case (st)
            S_START: st <= S_BIT;
            S_BIT: begin
              if (bitn == 3'd7) begin
                st   <= S_ACK;
                bitn <= '0;
              end else begin
                shreg <= {shreg[6:0], 1'b0};
                bitn  <= bitn + 3'd1;
              end
            end
            S_ACK: begin
              if (bad || second) begin
                st <= S_STOP;
              end else begin
                st     <= S_BIT;
                shreg  <= level_q;
                second <= 1'b1;
              end
            end
            S_STOP: begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  p_chan_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(chan_q) && $stable(level_q));

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(nack_ev));

  p_sda_lowphase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low && !$past(scl_low) && (sda_low != $past(sda_low)))
      |-> (st == S_START || st == S_STOP));

  p_tick_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    qend |-> busy);

endmodule

// File: rtl/dac_wr_route.sv
module dac_wr_route #(
  parameter int CHANNELS = 4,
  parameter int CH_W     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CH_W-1:0]     sel,
  input  logic                busy_i,
  input  logic                scl_low_i,
  input  logic                sda_low_i,
  input  logic [CHANNELS-1:0] sda_line,
  output logic [CHANNELS-1:0] scl_o,
  output logic [CHANNELS-1:0] sda_o,
  output logic                sda_s
);

  logic sda_m1;
  logic sel_sda;

  assign sel_sda = sda_line[sel];

  for (genvar g = 0; g < CHANNELS; g++) begin : g_pair
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        scl_o[g] <= 1'b0;
        sda_o[g] <= 1'b0;
      end else begin
        scl_o[g] <= busy_i && (sel == CH_W'(g)) && scl_low_i;
        sda_o[g] <= busy_i && (sel == CH_W'(g)) && sda_low_i;
      end
    end
  end

  // two-flop synchronizer on the selected data line
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sda_m1 <= 1'b1;
      sda_s  <= 1'b1;
    end else begin
      sda_m1 <= sel_sda;
      sda_s  <= sda_m1;
    end
  end

  p_rel_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy_i) |-> (scl_o == '0) && (sda_o == '0));

  p_one_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(scl_o) <= 1) && ($countones(sda_o) <= 1));

endmodule

// File: rtl/dac_bus_writer.sv
module dac_bus_writer
  import dac_wr_pkg::*;
#(
  parameter int         CHANNELS = 4,
  parameter int         CLK_HZ   = 50_000_000,
  parameter int         SCL_HZ   = 100_000,
  parameter logic [6:0] ADDR7    = 7'h4C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [1:0]    req_chan,
  input  logic [7:0]    req_level,
  input  logic          err_clr,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [3:0]    scl_drv_low,
  output logic [3:0]    sda_drv_low,
  input  logic [3:0]    sda_line
);

  localparam int QTR  = qtr_cycles(CLK_HZ, SCL_HZ);
  localparam int CH_W = 2;

  logic            qtick;
  logic            sda_s;
  logic            scl_low;
  logic            sda_low;
  logic [CH_W-1:0] chan_q;

  dac_wr_clkdiv #(.QTR(QTR)) div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .qtick (qtick)
  );

  dac_wr_engine #(.CH_W(CH_W), .ADDR7(ADDR7)) eng_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .req_chan  (req_chan),
    .req_level (req_level),
    .err_clr   (err_clr),
    .qtick     (qtick),
    .sda_s     (sda_s),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .chan_q    (chan_q),
    .scl_low   (scl_low),
    .sda_low   (sda_low)
  );

  dac_wr_route #(.CHANNELS(CHANNELS), .CH_W(CH_W)) route_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (chan_q),
    .busy_i    (busy),
    .scl_low_i (scl_low),
    .sda_low_i (sda_low),
    .sda_line  (sda_line),
    .scl_o     (scl_drv_low),
    .sda_o     (sda_drv_low),
    .sda_s     (sda_s)
  );

endmodule

// File: tb/dac_bus_writer_tb_top.sv
module dac_bus_writer_tb_top;

  localparam int         SCL_HZ = 1_250_000;
  localparam int         CLK_HZ = 50_000_000;
  localparam logic [6:0] DEV    = 7'h4C;
  localparam int         BITP   = CLK_HZ / SCL_HZ;   // cycles per SCL bit

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [1:0] req_chan = '0;
  logic [7:0] req_level = '0;
  logic       err_clr = 1'b0;
  logic       busy, done, err;
  logic [3:0] scl_drv_low, sda_drv_low, sda_line;
  logic [3:0] pull = '0;

  assign sda_line = ~(sda_drv_low | pull);

  always #10 clk = ~clk;

  dac_bus_writer #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .ADDR7(DEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_chan(req_chan),
    .req_level(req_level), .err_clr(err_clr), .busy(busy), .done(done),
    .err(err), .scl_drv_low(scl_drv_low), .sda_drv_low(sda_drv_low),
    .sda_line(sda_line)
  );

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  bit ended = 0;

  // responder / bus monitor state per pair
  bit   p_scl[4], p_sda[4];
  int   bitcnt[4], nbytes[4], starts[4], stops[4], hichg[4];
  int   last_rise[4], pmin[4], pmax[4];
  logic [7:0] sh[4], b0[4], b1[4];
  int   nack_idx = -1;
  int   done_cnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    for (int c = 0; c < 4; c++) begin
      nbytes[c] = 0; starts[c] = 0; stops[c] = 0; hichg[c] = 0;
      bitcnt[c] = 0; last_rise[c] = -1; pmin[c] = 1 << 30; pmax[c] = 0;
      b0[c] = 'x; b1[c] = 'x;
    end
    done_cnt = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (done) done_cnt++;
    for (int c = 0; c < 4; c++) begin
      bit scl, sda;
      scl = !scl_drv_low[c];
      sda = sda_line[c];
      if (p_scl[c] && scl && (p_sda[c] != sda)) begin
        hichg[c]++;
        if (!sda) begin
          starts[c]++; bitcnt[c] = 0; nbytes[c] = 0; last_rise[c] = -1;
        end else stops[c]++;
      end else if (!p_scl[c] && scl) begin
        if (last_rise[c] >= 0) begin
          if (cyc - last_rise[c] < pmin[c]) pmin[c] = cyc - last_rise[c];
          if (cyc - last_rise[c] > pmax[c]) pmax[c] = cyc - last_rise[c];
        end
        last_rise[c] = cyc;
        if (bitcnt[c] < 8) sh[c] = {sh[c][6:0], sda};
        bitcnt[c]++;
      end else if (p_scl[c] && !scl) begin
        if (bitcnt[c] == 8) begin
          pull[c] = (nbytes[c] != nack_idx);
        end else if (bitcnt[c] == 9) begin
          pull[c] = 1'b0;
          if (nbytes[c] == 0) b0[c] = sh[c]; else b1[c] = sh[c];
          nbytes[c]++;
          bitcnt[c] = 0;
        end
      end
      p_scl[c] = scl;
      p_sda[c] = sda;
    end
  end

  task automatic wait_done();
    int lim = 0;
    while (!done && lim < 5000) begin @(negedge clk); lim++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic launch(input int ch, input logic [7:0] lvl);
    @(negedge clk);
    req = 1'b1; req_chan = 2'(ch); req_level = lvl;
    @(negedge clk);
    req = 1'b0;
  endtask

  // full transfer with checks; nk = byte index left unacknowledged (-1 none)
  task automatic xfer(input int ch, input logic [7:0] lvl, input int nk, input bit exp_err);
    int others;
    clear_mon();
    nack_idx = nk;
    launch(ch, lvl);
    chk(busy === 1'b1, "R4 busy after accept", busy, 1);
    wait_done();
    others = 0;
    for (int c = 0; c < 4; c++) if (c != ch) others += starts[c] + hichg[c];
    chk(starts[ch] == 1 && stops[ch] == 1, "R2 start/stop count", starts[ch]*10+stops[ch], 11);
    chk(b0[ch] == {DEV, 1'b0}, "R2 address byte", b0[ch], {DEV, 1'b0});
    chk(others == 0, "R3 other pairs quiet", others, 0);
    chk(done_cnt == 1, "R5 single done pulse", done_cnt, 1);
    chk(busy === 1'b0, "R5 idle after done", busy, 0);
    chk(hichg[ch] == 2, "R10 sda changes with scl high", hichg[ch], 2);
    chk(pmin[ch] == BITP && pmax[ch] == BITP, "R9 scl bit period", pmax[ch], BITP);
    chk(scl_drv_low == 0 && sda_drv_low == 0, "R3 all pairs released", scl_drv_low, 0);
    if (nk == 0) begin
      chk(nbytes[ch] == 1, "R6 level byte withheld", nbytes[ch], 1);
      chk(err === 1'b1, "R6 error set", err, 1);
    end else if (nk == 1) begin
      chk(nbytes[ch] == 2 && b1[ch] == lvl, "R7 level byte sent", b1[ch], lvl);
      chk(err === 1'b1, "R7 error set", err, 1);
    end else begin
      chk(nbytes[ch] == 2 && b1[ch] == lvl, "R2 level byte", b1[ch], lvl);
      chk(err === exp_err, "R8 error state", err, exp_err);
    end
    nack_idx = -1;
  endtask

  initial begin
    while (!ended && cyc < 150000) @(negedge clk);
    if (!ended) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats[5];
    for (int c = 0; c < 4; c++) begin p_scl[c] = 1; p_sda[c] = 1; end
    clear_mon();
    repeat (5) @(negedge clk);
    chk(busy === 0 && done === 0 && err === 0, "R1 reset flags", {busy, done, err}, 0);
    chk(scl_drv_low === 0 && sda_drv_low === 0, "R1 lines released", sda_drv_low, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // sweep every pair with several level patterns
    for (int c = 0; c < 4; c++) begin
      pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;
      pats[4] = 8'(c * 37 + 1);
      for (int p = 0; p < 5; p++) xfer(c, pats[p], -1, 1'b0);
    end

    // R6: address not acknowledged; R8 stickiness across a good transfer
    xfer(2, 8'h3C, 0, 1'b1);
    xfer(1, 8'h81, -1, 1'b1);
    @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    @(negedge clk);
    chk(err === 1'b0, "R8 cleared by err_clr", err, 0);

    // R7: level byte not acknowledged on each pair
    for (int c = 0; c < 4; c++) begin
      xfer(c, 8'(8'hC0 + c), 1, 1'b1);
      @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    end

    // R4: request while busy is ignored
    clear_mon();
    launch(0, 8'h6E);
    repeat (100) @(negedge clk);
    req = 1'b1; req_chan = 2'd3; req_level = 8'h11;
    @(negedge clk);
    req = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    chk(starts[3] == 0, "R4 busy request ignored", starts[3], 0);
    chk(b1[0] == 8'h6E, "R4 level unchanged", b1[0], 8'h6E);
    chk(busy === 0, "R4 no queued transfer", busy, 0);

    ended = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule